// File: doc/BRIEF.md
# Pipelined DES Round-Key Generator with Delay Skew

This block feeds the sixteen round stages of a fully pipelined DES datapath that accepts one 64-bit block per clock. With each block it takes a 64-bit key, a valid flag and a direction select. It produces all sixteen 48-bit round keys in parallel. Each round key is fixed wiring from the key input: the permuted-choice selections and the cumulative half-rotations are resolved when the design is elaborated, so no shift register runs at run time.

The round keys then pass through a triangular array of registers. Round key k (numbered from 1) goes through k-1 registers, so it reaches stage k of the round pipeline in the same clock as the data block it was presented with. Round 1 is taken directly from the inputs and has no register. Because every register carries its own block's key, the key and the direction may change on every clock with no stall. A delayed copy of the valid flag goes with every stage. A register only advances when a valid block moves into it, so bubbles in the stream leave the keys already in flight untouched.

Top module: `des_subkey_skew`

## Requirements
- R1: Key input bits keyIn[0], keyIn[8], keyIn[16], ... keyIn[56] (the parity bits) have no effect on any round key.
- R2: Stage 0 (subkeysOut[47:0]) is the round-1 key of the current keyIn and decrypt inputs in the same cycle, with no register, whether keyValid is high or low.
- R3: The round key for stage s (subkeysOut[s*48 +: 48], s = 1..15) belongs to the valid input presented s clock edges earlier.
- R4: Round keys follow the standard DES schedule: permuted choice 1, left rotations of both 28-bit halves by 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1 per round, then permuted choice 2. keyIn[63] is key bit 1 and subkey bit 1 is bit 47 of each bus. For key 0x133457799BBCDFF1, round 1 is 0x1B02EFFC7072 and round 16 is 0xCB3D8B0E17F5.
- R5: With decrypt high, stage s carries round key 16-s, so stage 0 gets round key 16. The select is captured together with its key and travels with it.
- R6: A different key and direction may be presented on every clock, and each stage still shows the key of its own block.
- R7: When the block arriving at stage s is not valid (stageValid[s-1] low at the edge), the stage s round key keeps its previous value.
- R8: stageValid[0] equals keyValid, and stageValid[s] equals stageValid[s-1] from one clock earlier.
- R9: A synchronous reset (rst high at an edge) clears every skew register and stageValid[15:1] to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| keyIn | input | 64 | Key for the block entering the pipeline this cycle |
| keyValid | input | 1 | A block enters the pipeline this cycle |
| decrypt | input | 1 | 1 = reverse round-key order for this block |
| subkeysOut | output | 768 | Round key for stage s at bits [s*48 +: 48] |
| stageValid | output | 16 | Stage s holds a valid block |

## Verification
On every cycle the assertions check three things: the valid flags ripple one stage per clock, a stage whose incoming block is a bubble keeps its key, and reset clears all delayed stages. The values of the keys, their alignment to the block ages, and the reversal for decryption can only be shown by the bench. Its scenarios compare every stage each cycle against a shift-based key schedule applied to a history of inputs, with known test keys, flipped parity bits, full-rate random keys and directions, random bubbles, long idle stretches and a reset in mid-stream.

// File: rtl/des_keysched_pkg.sv
package des_keysched_pkg;

  localparam int NUM_ROUNDS = 16;
  localparam int SUBKEY_W   = 48;
  localparam int KEY_W      = 64;
  localparam int HALF_W     = 28;
  localparam int CD_W       = 2 * HALF_W;

  // Permuted choice 1: CD position (1-based, MSB first) <- key bit number
  localparam int PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };

  // Permuted choice 2: subkey position <- CD position
  localparam int PC2_TAB [SUBKEY_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  localparam int SHIFT_TAB [NUM_ROUNDS] = '{
    1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1
  };

  // Total rotation applied to each half by the end of round (0-based)
  function automatic int cumShift(input int round);
    int acc;
    acc = 0;
    for (int i = 0; i <= round; i++) acc += SHIFT_TAB[i];
    return acc;
  endfunction

  // keyIn index feeding subkey bit j (j = 0 is the MSB) of round (0-based)
  function automatic int srcBit(input int round, input int j);
    int q;
    int sh;
    int pos;
    q  = PC2_TAB[j];
    sh = cumShift(round);
    if (q <= HALF_W) pos = ((q - 1 + sh) % HALF_W) + 1;
    else             pos = HALF_W + ((q - HALF_W - 1 + sh) % HALF_W) + 1;
    return KEY_W - PC1_TAB[pos - 1];
  endfunction

  typedef struct packed {
    logic                  clear;
    logic [NUM_ROUNDS-2:0] loadEn;   // loadEn[d-1]: depth d registers advance
  } skew_ctrl_t;

endpackage

// File: rtl/keysched_ctrl.sv
module keysched_ctrl
  import des_keysched_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  keyValid,
  output skew_ctrl_t            ctrl,
  output logic [NUM_ROUNDS-1:0] stageValid
);

  logic [NUM_ROUNDS-1:1] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= stageValid[NUM_ROUNDS-2:0];
  end

  assign stageValid  = {validPipe, keyValid};
  assign ctrl.clear  = rst;
  assign ctrl.loadEn = stageValid[NUM_ROUNDS-2:0];

endmodule

// File: rtl/keysched_select.sv
module keysched_select
  import des_keysched_pkg::*;
(
  input  logic [KEY_W-1:0]                     keyIn,
  input  logic                                 decrypt,
  output logic [NUM_ROUNDS-1:0][SUBKEY_W-1:0]  roundKeys
);

  logic [NUM_ROUNDS-1:0][SUBKEY_W-1:0] rawKeys;

  for (genvar r = 0; r < NUM_ROUNDS; r++) begin : g_round
    for (genvar j = 0; j < SUBKEY_W; j++) begin : g_bit
      localparam int SRC = srcBit(r, j);
      assign rawKeys[r][SUBKEY_W-1-j] = keyIn[SRC];
    end
    assign roundKeys[r] = decrypt ? rawKeys[NUM_ROUNDS-1-r] : rawKeys[r];
  end

endmodule

// File: rtl/keysched_skew.sv
module keysched_skew
  import des_keysched_pkg::*;
(
  input  logic                                 clk,
  input  skew_ctrl_t                           ctrl,
  input  logic [NUM_ROUNDS-1:0][SUBKEY_W-1:0]  roundKeys,
  output logic [NUM_ROUNDS*SUBKEY_W-1:0]       subkeysOut
);

  assign subkeysOut[SUBKEY_W-1:0] = roundKeys[0];

  for (genvar s = 1; s < NUM_ROUNDS; s++) begin : g_stage
    logic [SUBKEY_W-1:0] chain [1:s];

    always_ff @(posedge clk) begin
      if (ctrl.clear) begin
        for (int d = 1; d <= s; d++) chain[d] <= '0;
      end else begin
        if (ctrl.loadEn[0]) chain[1] <= roundKeys[s];
        for (int d = 2; d <= s; d++)
          if (ctrl.loadEn[d-1]) chain[d] <= chain[d-1];
      end
    end

    assign subkeysOut[s*SUBKEY_W +: SUBKEY_W] = chain[s];
  end

endmodule

// File: rtl/des_subkey_skew.sv
module des_subkey_skew
  import des_keysched_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic [KEY_W-1:0]                 keyIn,
  input  logic                             keyValid,
  input  logic                             decrypt,
  output logic [NUM_ROUNDS*SUBKEY_W-1:0]   subkeysOut,
  output logic [NUM_ROUNDS-1:0]            stageValid
);

  skew_ctrl_t                          ctrl;
  logic [NUM_ROUNDS-1:0][SUBKEY_W-1:0] roundKeys;

  keysched_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .keyValid   (keyValid),
    .ctrl       (ctrl),
    .stageValid (stageValid)
  );

  keysched_select u_select (
    .keyIn     (keyIn),
    .decrypt   (decrypt),
    .roundKeys (roundKeys)
  );

  keysched_skew u_skew (
    .clk        (clk),
    .ctrl       (ctrl),
    .roundKeys  (roundKeys),
    .subkeysOut (subkeysOut)
  );

endmodule

// File: rtl/des_subkey_skew_chk.sv
module des_subkey_skew_chk
  import des_keysched_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic                           keyValid,
  input logic [NUM_ROUNDS*SUBKEY_W-1:0] subkeysOut,
  input logic [NUM_ROUNDS-1:0]          stageValid
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stageValid[NUM_ROUNDS-1:1] == '0 &&
             subkeysOut[NUM_ROUNDS*SUBKEY_W-1:SUBKEY_W] == '0)); // R9

  AST_STAGE0_VALID: assert property (@(posedge clk) disable iff (rst)
    stageValid[0] == keyValid); // R8

  for (genvar s = 1; s < NUM_ROUNDS; s++) begin : g_chk
    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
      stageValid[s-1] |=> stageValid[s]); // R8
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
      !stageValid[s-1] |=> !stageValid[s]); // R8
    AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !stageValid[s-1] |=> $stable(subkeysOut[s*SUBKEY_W +: SUBKEY_W])); // R7
  end

endmodule

bind des_subkey_skew des_subkey_skew_chk u_chk (.*);

// File: tb/sim_des_subkey_skew.sv
module sim_des_subkey_skew;

  localparam int NR = 16;
  localparam int SW = 48;

  localparam int PC1 [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };
  localparam int PC2 [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };
  localparam int ROT [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

  typedef struct {
    logic [63:0] key;
    logic        dec;
    logic        vld;
  } rec_t;

  logic              clk = 0;
  logic              rst = 1;
  logic [63:0]       keyIn = '0;
  logic              keyValid = 0;
  logic              decrypt = 0;
  logic [NR*SW-1:0]  subkeysOut;
  logic [NR-1:0]     stageValid;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  rec_t hist[$];

  always #2 clk = ~clk;

  des_subkey_skew u0 (
    .clk        (clk),
    .rst        (rst),
    .keyIn      (keyIn),
    .keyValid   (keyValid),
    .decrypt    (decrypt),
    .subkeysOut (subkeysOut),
    .stageValid (stageValid)
  );

  // Shift-based key schedule, round n in 1..16
  function automatic logic [47:0] refSub(input logic [63:0] k, input int n);
    logic [55:0] cd;
    logic [27:0] c, d;
    logic [47:0] o;
    for (int i = 0; i < 56; i++) cd[55-i] = k[64-PC1[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < n; r++)
      for (int t = 0; t < ROT[r]; t++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
    cd = {c, d};
    for (int j = 0; j < 48; j++) o[47-j] = cd[56-PC2[j]];
    return o;
  endfunction

  function automatic logic [47:0] stageKey(input rec_t r, input int s);
    return refSub(r.key, r.dec ? (NR - s) : (s + 1));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare every stage against the history model
  task automatic checkAll(input string tag);
    rec_t cur;
    cur.key = keyIn; cur.dec = decrypt; cur.vld = keyValid;
    check({tag, " R2 stage0 key"}, {16'h0, subkeysOut[SW-1:0]}, {16'h0, stageKey(cur, 0)});
    check({tag, " R8 stage0 valid"}, {63'h0, stageValid[0]}, {63'h0, keyValid});
    for (int s = 1; s < NR; s++) begin
      logic [47:0] ek;
      logic        ev;
      ek = '0;
      ev = (hist.size() >= s) ? hist[s-1].vld : 1'b0;
      for (int i = s - 1; i < hist.size(); i++)
        if (hist[i].vld) begin
          ek = stageKey(hist[i], s);
          break;
        end
      check($sformatf("%s R3/R7 stage%0d key", tag, s),
            {16'h0, subkeysOut[s*SW +: SW]}, {16'h0, ek});
      check($sformatf("%s R8 stage%0d valid", tag, s),
            {63'h0, stageValid[s]}, {63'h0, ev});
    end
  endtask

  task automatic step(input logic [63:0] k, input logic d, input logic v,
                      input logic r, input string tag);
    rec_t nr;
    @(negedge clk);
    keyIn = k; decrypt = d; keyValid = v; rst = r;
    #1 checkAll(tag);
    @(posedge clk);
    if (r) hist.delete();
    else begin
      nr.key = k; nr.dec = d; nr.vld = v;
      hist.push_front(nr);
    end
  endtask

  function automatic logic [63:0] rndKey();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] kv;
    kv = 64'h133457799BBCDFF1;
    repeat (3) @(posedge clk);
    // R9: reset state, all stages clear
    step(64'h0, 0, 0, 0, "R9 reset state");

    // R4 / R5 / R1 known vectors on the combinational stage
    @(negedge clk);
    keyIn = kv; decrypt = 0; keyValid = 0;
    #1 check("R4 round1 known", {16'h0, subkeysOut[47:0]}, {16'h0, 48'h1B02EFFC7072});
    decrypt = 1;
    #1 check("R5 decrypt stage0 is round16", {16'h0, subkeysOut[47:0]}, {16'h0, 48'hCB3D8B0E17F5});
    keyIn = kv ^ 64'h0101010101010101;
    #1 check("R1 parity flip decrypt", {16'h0, subkeysOut[47:0]}, {16'h0, 48'hCB3D8B0E17F5});
    decrypt = 0;
    #1 check("R1 parity flip encrypt", {16'h0, subkeysOut[47:0]}, {16'h0, 48'h1B02EFFC7072});

    // R1: parity bits alone through the whole pipeline
    for (int i = 0; i < 20; i++) step(kv ^ {$urandom, $urandom} & 64'h0101010101010101,
                                      1'(i % 3 == 0), 1, 0, "R1 parity stream");
    for (int i = 0; i < 20; i++) step(kv, 0, 1, 0, "R1 parity settle");

    // R6: new key every clock, encrypt only
    for (int i = 0; i < 200; i++) step(rndKey(), 0, 1, 0, "R6 full rate");
    // R5: direction toggles per block
    for (int i = 0; i < 200; i++) step(rndKey(), 1'($urandom), 1, 0, "R5 mixed direction");
    // R7: random bubbles
    for (int i = 0; i < 300; i++) step(rndKey(), 1'($urandom), 1'($urandom % 3 != 0), 0, "R7 bubbles");
    // R7: long idle with changing inputs
    for (int i = 0; i < 40; i++) step(rndKey(), 1'($urandom), 0, 0, "R7 idle hold");
    // R3: isolated blocks
    for (int i = 0; i < 60; i++) step(rndKey(), 1'($urandom), 1'(i % 17 == 0), 0, "R3 isolated");
    // R9: reset mid-stream
    for (int i = 0; i < 10; i++) step(rndKey(), 0, 1, 0, "R9 prefill");
    step(rndKey(), 0, 1, 1, "R9 reset cycle");
    for (int i = 0; i < 20; i++) step(rndKey(), 1'($urandom), 1'(i > 5), 0, "R9 after reset");
    for (int i = 0; i < 100; i++) step(rndKey(), 1'($urandom), 1'($urandom), 0, "R6 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule